// File: doc/BRIEF.md
# Outstanding Request Deadlock Watchdog

This block watches a small table of in-flight memory requests and raises a fault when some request has gone unanswered for too long. The table itself lives elsewhere; the watchdog receives a valid bit and an issue timestamp for every read-class and write-class slot, the table's own count of live entries, a free-running cycle counter, a pulse for each new insertion and a drain indication.

The watchdog does not time every entry on every cycle. It keeps one deadline. An insertion arms it one threshold period ahead when nothing is pending. When the deadline arrives, all slots of both classes are scanned in a single cycle. While work remains, the next deadline is set one more period ahead; otherwise the watchdog falls idle until the next insertion. The same scan also compares the reported live count with the number of valid slots. Once raised, the fault holds until reset, together with the slot index and the age of the first offender.

Top module: `deadlock_watchdog`

## Requirements
- R1: At a scan, a valid slot counts as stale when the cycle counter minus its issue time is greater than or equal to THRESH. A slot whose age is THRESH-1 or less at that scan raises nothing.
- R2: An insertion pulse seen while no scan is pending (and no drain is active) schedules a scan at the sampled cycle counter plus THRESH. An insertion seen while a scan is already pending leaves that deadline unchanged.
- R3: At a scan, the next scan is scheduled THRESH cycles later if the live count is non-zero or an insertion arrives in that cycle. Otherwise the watchdog goes idle and makes no scan until a later insertion, however stale the slots become meanwhile.
- R4: Each scan covers read slots and write slots. Slots are numbered with read slot k as index k and write slot k as index NRD+k.
- R5: When several slots are stale at the same scan, `fault_index_o` gives the lowest stale index and `fault_age_o` gives that slot's age at the scan.
- R6: At a scan, a live count that differs from the number of valid read slots plus valid write slots sets `fault_count_o`. It does not set `fault_stale_o`.
- R7: While `drain_i` is high, no scan is armed: an insertion does not schedule one, and a scan does not schedule a follow-on.
- R8: `fault_stale_o`, `fault_count_o` and `fault_o` are sticky until reset. The index and age recorded by the first stale detection do not change at later scans.
- R9: After reset all outputs are zero and no scan is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cycle_now_i | input | TW | Free-running cycle counter |
| rd_valid_i | input | NRD | Valid bit per read-class slot |
| rd_issue_i | input | NRD*TW | Issue cycle per read slot, slot k in bits [k*TW +: TW] |
| wr_valid_i | input | NWR | Valid bit per write-class slot |
| wr_issue_i | input | NWR*TW | Issue cycle per write slot, slot k in bits [k*TW +: TW] |
| live_count_i | input | CW | Live-entry count reported by the table |
| insert_i | input | 1 | One-cycle pulse per new table entry |
| drain_i | input | 1 | Drain in progress; blocks arming |
| fault_o | output | 1 | Either fault kind has occurred |
| fault_stale_o | output | 1 | A stale slot was found |
| fault_count_o | output | 1 | A live-count mismatch was found |
| fault_index_o | output | IW | Index of the first reported stale slot |
| fault_age_o | output | TW | Age of that slot at its scan |

## Verification
The scan happens at the clock edge where the sampled cycle counter first reaches the deadline, and the fault registers are visible one edge after that. A deadline equals the counter value sampled with the arming insertion plus THRESH. The bench advances the counter by one at each falling edge and reads outputs at the falling edge after the scan edge. For each scenario it checks that the fault is still clear at the falling edge just before the expected scan. It then checks the fault at the falling edge just after it. In this way it separates a scan at the correct epoch from one that is a cycle early, a cycle late, or a full period off because of wrong re-arming.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    SCH_IDLE  = 1'b0,
    SCH_ARMED = 1'b1
  } sched_e;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/wdog_scan.sv
module wdog_scan #(
  parameter int N      = 8,
  parameter int TW     = 32,
  parameter int THRESH = 64,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic [TW-1:0]   now_i,
  input  logic [N-1:0]    valid_i,
  input  logic [N*TW-1:0] issue_i,
  output logic            hit_o,
  output logic [IW-1:0]   idx_o,
  output logic [TW-1:0]   age_o
);

  logic [N-1:0]  stale;
  logic [TW-1:0] age [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    assign age[g]   = now_i - issue_i[g*TW +: TW];
    assign stale[g] = valid_i[g] && (age[g] >= TW'(THRESH));
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    age_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (stale[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
        age_o = age[i];
      end
    end
  end

endmodule

// File: rtl/wdog_tally.sv
module wdog_tally #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [N-1:0]  valid_i,
  input  logic [CW-1:0] count_i,
  output logic          mismatch_o
);

  logic [CW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) begin
      sum = sum + CW'(valid_i[i]);
    end
  end

  assign mismatch_o = (sum != count_i);

endmodule

// File: rtl/wdog_sched.sv
module wdog_sched
  import wdog_pkg::*;
#(
  parameter int TW     = 32,
  parameter int THRESH = 64,
  parameter int CW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now_i,
  input  logic [CW-1:0] live_count_i,
  input  logic          insert_i,
  input  logic          drain_i,
  output logic          armed_o,
  output logic          fire_o
);

  sched_e        st_q, st_d;
  logic [TW-1:0] due_q, due_d;
  logic          due_en;
  logic          work_left;

  assign work_left = (live_count_i != '0) || insert_i;
  assign fire_o    = (st_q == SCH_ARMED) && (now_i >= due_q);
  assign armed_o   = (st_q == SCH_ARMED);

  always_comb begin
    st_d   = st_q;
    due_d  = due_q;
    due_en = 1'b0;
    if (fire_o) begin
      if (work_left && !drain_i) begin
        due_d  = now_i + TW'(THRESH);
        due_en = 1'b1;
      end else begin
        st_d = SCH_IDLE;
      end
    end else if ((st_q == SCH_IDLE) && insert_i && !drain_i) begin
      st_d   = SCH_ARMED;
      due_d  = now_i + TW'(THRESH);
      due_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SCH_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      due_q <= '0;
    end else if (due_en) begin
      due_q <= due_d;
    end
  end

endmodule

// File: rtl/deadlock_watchdog.sv
module deadlock_watchdog #(
  parameter int NRD    = 4,
  parameter int NWR    = 4,
  parameter int TW     = 32,
  parameter int THRESH = 64,
  localparam int NE    = NRD + NWR,
  localparam int IW    = (NE > 1) ? $clog2(NE) : 1,
  localparam int CW    = $clog2(NE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     cycle_now_i,
  input  logic [NRD-1:0]    rd_valid_i,
  input  logic [NRD*TW-1:0] rd_issue_i,
  input  logic [NWR-1:0]    wr_valid_i,
  input  logic [NWR*TW-1:0] wr_issue_i,
  input  logic [CW-1:0]     live_count_i,
  input  logic              insert_i,
  input  logic              drain_i,
  output logic              fault_o,
  output logic              fault_stale_o,
  output logic              fault_count_o,
  output logic [IW-1:0]     fault_index_o,
  output logic [TW-1:0]     fault_age_o
);

  logic             rst_sync_n;
  logic [NE-1:0]    all_valid;
  logic [NE*TW-1:0] all_issue;
  logic             scan_hit;
  logic [IW-1:0]    scan_idx;
  logic [TW-1:0]    scan_age;
  logic             count_bad;
  logic             sched_armed;
  logic             check_fire;

  logic             stale_q, stale_d;
  logic             cnt_q, cnt_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [TW-1:0]    age_q, age_d;
  logic             rec_en;

  assign all_valid = {wr_valid_i, rd_valid_i};
  assign all_issue = {wr_issue_i, rd_issue_i};

  wdog_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdog_sched #(.TW(TW), .THRESH(THRESH), .CW(CW)) u_sched (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .now_i        (cycle_now_i),
    .live_count_i (live_count_i),
    .insert_i     (insert_i),
    .drain_i      (drain_i),
    .armed_o      (sched_armed),
    .fire_o       (check_fire)
  );

  wdog_scan #(.N(NE), .TW(TW), .THRESH(THRESH)) u_scan (
    .now_i   (cycle_now_i),
    .valid_i (all_valid),
    .issue_i (all_issue),
    .hit_o   (scan_hit),
    .idx_o   (scan_idx),
    .age_o   (scan_age)
  );

  wdog_tally #(.N(NE), .CW(CW)) u_tally (
    .valid_i    (all_valid),
    .count_i    (live_count_i),
    .mismatch_o (count_bad)
  );

  always_comb begin
    stale_d = stale_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    age_d   = age_q;
    rec_en  = 1'b0;
    if (check_fire) begin
      if (scan_hit && !stale_q) begin
        stale_d = 1'b1;
        idx_d   = scan_idx;
        age_d   = scan_age;
        rec_en  = 1'b1;
      end
      if (count_bad) begin
        cnt_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stale_q <= 1'b0;
      cnt_q   <= 1'b0;
    end else begin
      stale_q <= stale_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q <= '0;
      age_q <= '0;
    end else if (rec_en) begin
      idx_q <= idx_d;
      age_q <= age_d;
    end
  end

  assign fault_stale_o = stale_q;
  assign fault_count_o = cnt_q;
  assign fault_o       = stale_q | cnt_q;
  assign fault_index_o = idx_q;
  assign fault_age_o   = age_q;

endmodule

// File: rtl/deadlock_watchdog_chk.sv
module deadlock_watchdog_chk #(
  parameter int TW     = 32,
  parameter int THRESH = 64,
  parameter int IW     = 3,
  parameter int CW     = 4
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          armed,
  input logic          fire,
  input logic          insert,
  input logic          drain,
  input logic [CW-1:0] live_count,
  input logic          f_stale,
  input logic          f_count,
  input logic [IW-1:0] f_idx,
  input logic [TW-1:0] f_age
);

  // R1: a reported stale age never falls below the threshold
  p_age_at_least_thresh_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    f_stale |-> (f_age >= TW'(THRESH)));

  // R2: an accepted insertion while idle leaves a scan pending
  p_insert_arms_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!armed && insert && !drain) |=> armed);

  // R3: a scan with no work left makes the watchdog idle
  p_idle_after_empty_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire && (live_count == '0) && !insert) |=> !armed);

  // R7: drain keeps an idle watchdog idle
  p_drain_blocks_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (drain && !armed) |=> !armed);

  // R7: drain stops re-arming after a scan
  p_drain_no_rearm_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (drain && fire) |=> !armed);

  // R8: faults are sticky
  p_stale_sticky_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    f_stale |=> f_stale);

  p_count_sticky_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    f_count |=> f_count);

  // R8: recorded index and age hold once a stale fault exists
  p_record_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    f_stale |=> ($stable(f_idx) && $stable(f_age)));

  // R3: faults appear only as the result of a scan
  p_fault_needs_scan_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(f_stale) || $rose(f_count)) |-> $past(fire));

endmodule

bind deadlock_watchdog deadlock_watchdog_chk #(
  .TW(TW), .THRESH(THRESH), .IW(IW), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .armed      (sched_armed),
  .fire       (check_fire),
  .insert     (insert_i),
  .drain      (drain_i),
  .live_count (live_count_i),
  .f_stale    (fault_stale_o),
  .f_count    (fault_count_o),
  .f_idx      (fault_index_o),
  .f_age      (fault_age_o)
);

// File: tb/tb_deadlock_watchdog.sv
`timescale 1ns/1ps
module tb_deadlock_watchdog;

  localparam int NRD = 4;
  localparam int NWR = 4;
  localparam int TW  = 32;
  localparam int TH  = 8;
  localparam int NE  = NRD + NWR;
  localparam int IW  = $clog2(NE);
  localparam int CW  = $clog2(NE + 1);

  logic              clk;
  logic              rst_n;
  logic [TW-1:0]     cyc;
  logic [NRD-1:0]    rd_valid;
  logic [NRD*TW-1:0] rd_issue;
  logic [NWR-1:0]    wr_valid;
  logic [NWR*TW-1:0] wr_issue;
  logic [CW-1:0]     live;
  logic              insert;
  logic              drain;
  logic              fault, f_stale, f_count;
  logic [IW-1:0]     f_idx;
  logic [TW-1:0]     f_age;

  int checks = 0;
  int errors = 0;

  deadlock_watchdog #(.NRD(NRD), .NWR(NWR), .TW(TW), .THRESH(TH)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cycle_now_i   (cyc),
    .rd_valid_i    (rd_valid),
    .rd_issue_i    (rd_issue),
    .wr_valid_i    (wr_valid),
    .wr_issue_i    (wr_issue),
    .live_count_i  (live),
    .insert_i      (insert),
    .drain_i       (drain),
    .fault_o       (fault),
    .fault_stale_o (f_stale),
    .fault_count_o (f_count),
    .fault_index_o (f_idx),
    .fault_age_o   (f_age)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic expect_out(input string req, input bit e_stale, input bit e_cnt,
                            input int e_idx, input int e_age);
    chk(f_stale == e_stale, req, f_stale, e_stale);
    chk(f_count == e_cnt, req, f_count, e_cnt);
    chk(fault == (e_stale | e_cnt), req, fault, e_stale | e_cnt);
    if (e_stale) begin
      chk(f_idx == IW'(e_idx), req, f_idx, e_idx);
      chk(f_age == TW'(e_age), req, f_age, e_age);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc = cyc + 1;
  endtask

  // advance until the next rising edge samples the counter value t
  task automatic tick_to(input int t);
    while (cyc != TW'(t)) tick();
  endtask

  task automatic pulse_insert();
    insert = 1'b1;
    tick();
    insert = 1'b0;
  endtask

  task automatic set_rd(input int k, input bit v, input int t);
    rd_valid[k] = v;
    rd_issue[k*TW +: TW] = TW'(t);
  endtask

  task automatic set_wr(input int k, input bit v, input int t);
    wr_valid[k] = v;
    wr_issue[k*TW +: TW] = TW'(t);
  endtask

  task automatic do_reset(input int base);
    rst_n = 1'b0;
    rd_valid = '0; rd_issue = '0; wr_valid = '0; wr_issue = '0;
    live = '0; insert = 1'b0; drain = 1'b0;
    cyc = TW'(base - 6);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  // R9: outputs clear after reset
  task automatic t_reset();
    do_reset(50);
    expect_out("R9", 0, 0, 0, 0);
    chk(f_idx == '0 && f_age == '0, "R9", f_age, 0);
  endtask

  // R1 R2: age exactly THRESH at the first scan is stale
  task automatic t_boundary();
    do_reset(100);
    set_rd(0, 1, 100); live = 1;
    pulse_insert();
    tick_to(108);
    expect_out("R2 no scan before deadline", 0, 0, 0, 0);
    tick_to(109);
    expect_out("R1 age equal to threshold", 1, 0, 0, 8);
  endtask

  // R1 R3: age THRESH-1 passes, re-armed scan catches it later
  task automatic t_rearm();
    do_reset(200);
    set_rd(0, 1, 201); live = 1;
    pulse_insert();
    tick_to(209);
    expect_out("R1 age below threshold passes", 0, 0, 0, 0);
    tick_to(216);
    expect_out("R3 no scan before re-armed deadline", 0, 0, 0, 0);
    tick_to(217);
    expect_out("R3 re-armed scan", 1, 0, 0, 15);
  endtask

  // R2: insertion while pending keeps the deadline
  task automatic t_pending_insert();
    do_reset(300);
    set_rd(0, 1, 300); live = 1;
    pulse_insert();
    tick_to(304);
    set_rd(1, 1, 304); live = 2;
    pulse_insert();
    tick_to(306);
    set_rd(0, 0, 0); live = 1;
    tick_to(309);
    expect_out("R2 first deadline kept", 0, 0, 0, 0);
    tick_to(316);
    expect_out("R2 deadline not moved", 0, 0, 0, 0);
    tick_to(317);
    expect_out("R2 second epoch", 1, 0, 1, 12);
  endtask

  // R3 R4: idle watchdog ignores stale slots until an insertion
  task automatic t_idle();
    do_reset(400);
    set_rd(0, 1, 400); live = 1;
    pulse_insert();
    tick_to(405);
    set_rd(0, 0, 0); live = 0;
    tick_to(409);
    expect_out("R3 empty scan", 0, 0, 0, 0);
    set_wr(2, 1, 300); live = 1;
    tick_to(440);
    expect_out("R3 idle makes no scan", 0, 0, 0, 0);
    pulse_insert();
    tick_to(448);
    expect_out("R3 new arm waits", 0, 0, 0, 0);
    tick_to(449);
    expect_out("R4 write slot index NRD+2", 1, 0, NRD + 2, 148);
  endtask

  // R4 R5 R8: lowest index wins, record sticks
  task automatic t_priority_sticky();
    do_reset(500);
    set_rd(2, 1, 496); set_rd(3, 1, 490); set_wr(1, 1, 480); live = 3;
    pulse_insert();
    tick_to(509);
    expect_out("R5 lowest stale index", 1, 0, 2, 12);
    tick_to(510);
    rd_valid = '0; wr_valid = '0; live = 0;
    tick_to(520);
    set_wr(0, 1, 400); live = 1;
    pulse_insert();
    tick_to(540);
    expect_out("R8 sticky record", 1, 0, 2, 12);
  endtask

  // R6: count mismatch flagged alone
  task automatic t_mismatch();
    do_reset(600);
    set_rd(0, 1, 605); live = 2;
    pulse_insert();
    tick_to(608);
    expect_out("R6 before scan", 0, 0, 0, 0);
    tick_to(609);
    expect_out("R6 count mismatch", 0, 1, 0, 0);
    live = 1; set_rd(0, 0, 0); live = 0;
    tick_to(630);
    expect_out("R8 count fault sticky", 0, 1, 0, 0);
  endtask

  // R7: drain blocks arming
  task automatic t_drain();
    do_reset(700);
    drain = 1'b1;
    set_rd(0, 1, 700); live = 1;
    pulse_insert();
    tick_to(730);
    expect_out("R7 insert during drain ignored", 0, 0, 0, 0);
    drain = 1'b0;
    pulse_insert();
    tick_to(738);
    expect_out("R7 arm after drain waits", 0, 0, 0, 0);
    tick_to(739);
    expect_out("R7 arm after drain", 1, 0, 0, 38);
    drain = 1'b1;
    tick();
    do_reset(800);
    expect_out("R9 reset clears sticky", 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_boundary();
    t_rearm();
    t_pending_insert();
    t_idle();
    t_priority_sticky();
    t_mismatch();
    t_drain();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule